// File: doc/BRIEF.md
# Four-Mode Terminal-Count Timer

This block is one down-counting interval timer with one output pin. Software writes a terminal count (TC) and a two-bit mode code into a holding register, then issues a start command. The counter loads the held TC and counts down one step per clock. Each time it reaches its last step it raises a sticky terminal-count flag, and in the repeating modes it reloads itself. The output shape depends on the mode. Two modes give square waves, split into a high half and a low half. The other two give one-clock active-low pulses. Each shape comes in a one-shot form and a repeating form.

Settings written while the timer runs are held back until the next terminal count, so the output never gets a shortened or mixed period. A stop command returns the timer to idle, and the output is high whenever the timer is idle. Reading the flag is signalled by a one-cycle strobe that clears it.

The count width is a parameter (14 bits by default). A second parameter, `REG_OUT`, adds an output flop that delays the output by one cycle. The requirements below describe the default configuration, where the output is decoded directly from the counter state.

Top module: `tc_wave_timer`

## Requirements
- R1: After reset the output `tmr_out` is 1, `tc_flag` is 0 and the timer is idle.
- R2: Mode code 2'b00 (single square wave): call the clock period that follows the start edge cycle 1. In cycles 1 to ceil(T/2) the output is 1. In cycles ceil(T/2)+1 to T it is 0. From cycle T+1 on it is 1 and stays idle. Here T is the effective TC.
- R3: Mode code 2'b01 (repeating square wave): the square wave of R2 repeats with a period of T cycles, with no idle cycle between periods, until stopped.
- R4: Mode code 2'b10 (single pulse): the output is 0 in cycle T only and 1 in every other cycle.
- R5: Mode code 2'b11 (repeating pulse): the output is 0 in every cycle whose number is a multiple of T and 1 otherwise, until stopped.
- R6: A written TC of 0 or 1 behaves exactly as a TC of 2.
- R7: A write (`cfg_wr` high) while the timer runs does not disturb the period in progress. The new TC and mode take effect from the cycle after the next terminal count.
- R8: A stop (`stop_cmd` high at an edge) makes the output 1 from the next cycle and stops further terminal counts. If stop and start are high at the same edge, stop wins.
- R9: `tc_flag` becomes 1 in the cycle after each terminal count (cycle T, or each multiple of T). It becomes 0 in the cycle after a `flag_rd` strobe. If a strobe and a terminal count meet at the same edge, the flag is set.
- R10: Writing settings without a start leaves the output at 1 and the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for `cfg_tc` and `cfg_mode` |
| cfg_tc | input | CNT_W | Terminal count to hold |
| cfg_mode | input | 2 | Mode code: 00 single square, 01 repeating square, 10 single pulse, 11 repeating pulse |
| start_cmd | input | 1 | Loads the held settings and starts counting |
| stop_cmd | input | 1 | Returns the timer to idle |
| flag_rd | input | 1 | Flag read strobe; clears `tc_flag` |
| tmr_out | output | 1 | Timer output |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
The hardest case to reach is a reprogramming write that lands inside a running period. The old waveform must finish intact and the new one must begin exactly at the terminal count. The bench reaches this by starting a repeating square wave and then writing a repeating-pulse setting with a different TC two cycles in. It checks every cycle on both sides of the boundary. A second hard case is a flag read strobe that arrives on the same edge as a terminal count. The bench aligns the strobe with the third cycle of a TC of 3 and checks that the flag still reads as set.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
   typedef enum logic [1:0] {
      TCW_SQ_ONE = 2'b00,
      TCW_SQ_REP = 2'b01,
      TCW_PL_ONE = 2'b10,
      TCW_PL_REP = 2'b11
   } tcw_mode_e;

   function automatic logic mode_repeats(input tcw_mode_e m);
      return m[0];
   endfunction

   function automatic logic mode_is_pulse(input tcw_mode_e m);
      return m[1];
   endfunction
endpackage

// File: rtl/tcw_cfg.sv
module tcw_cfg
   import tcw_pkg::*;
#(
   parameter int CNT_W  = 14,
   parameter int MIN_TC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_tc,
   input  logic [1:0]       wr_mode,
   output logic [CNT_W-1:0] hold_tc,
   output tcw_mode_e        hold_mode
);
   localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(MIN_TC);

   logic [CNT_W-1:0] tc_eff;
   assign tc_eff = (wr_tc < TC_FLOOR) ? TC_FLOOR : wr_tc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_tc   <= TC_FLOOR;
         hold_mode <= TCW_SQ_ONE;
      end else if (wr) begin
         hold_tc   <= tc_eff;
         hold_mode <= tcw_mode_e'(wr_mode);
      end
   end

   // R6: the held count never falls under the floor
   a_r6_hold_floor: assert property (@(posedge clk) disable iff (!rst_n)
      hold_tc >= TC_FLOOR);
endmodule

// File: rtl/tcw_core.sv
module tcw_core
   import tcw_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [CNT_W-1:0] hold_tc,
   input  tcw_mode_e        hold_mode,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act_tc,
   output tcw_mode_e        act_mode,
   output logic             term
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign term = run && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         cnt      <= ONE;
         act_tc   <= CNT_W'(2);
         act_mode <= TCW_SQ_ONE;
      end else if (stop) begin
         run <= 1'b0;
      end else if (start) begin
         run      <= 1'b1;
         cnt      <= hold_tc;
         act_tc   <= hold_tc;
         act_mode <= hold_mode;
      end else if (run) begin
         if (cnt == ONE) begin
            cnt      <= hold_tc;
            act_tc   <= hold_tc;
            act_mode <= hold_mode;
            if (!mode_repeats(act_mode)) run <= 1'b0;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   // R2: a running count stays within 1..active TC
   a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt >= ONE) && (cnt <= act_tc));
   // R6: an active TC below two is never used
   a_r6_act_floor: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> act_tc >= CNT_W'(2));
   // R3: one step per clock between terminal counts
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt != ONE && !start && !stop) |=> (run && cnt == $past(cnt) - ONE));
   // R4: single-shot modes go idle after their terminal count
   a_r4_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (term && !mode_repeats(act_mode) && !start && !stop) |=> !run);
   // R8: stop always wins
   a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !run);
endmodule

// File: rtl/tcw_flag.sv
module tcw_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   // R9: a terminal count is never lost to a read strobe
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
endmodule

// File: rtl/tcw_wave.sv
module tcw_wave
   import tcw_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] act_tc,
   input  tcw_mode_e        act_mode,
   output logic             wave
);
   logic [CNT_W-1:0] half;
   logic             raw;

   assign half = act_tc >> 1;

   always_comb begin
      if (!run)                        raw = 1'b1;
      else if (mode_is_pulse(act_mode)) raw = (cnt != CNT_W'(1));
      else                             raw = (cnt > half);
   end

   generate
      if (REG_OUT) begin : g_flop
         logic wave_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wave_q <= 1'b1;
            else        wave_q <= raw;
         end
         assign wave = wave_q;
      end else begin : g_comb
         assign wave = raw;
      end
   endgenerate
endmodule

// File: rtl/tc_wave_timer.sv
module tc_wave_timer
   import tcw_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_tc,
   input  logic [1:0]       cfg_mode,
   input  logic             start_cmd,
   input  logic             stop_cmd,
   input  logic             flag_rd,
   output logic             tmr_out,
   output logic             tc_flag
);
   localparam int MIN_TC = 2;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tc_wave_timer: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] hold_tc, cnt, act_tc;
   tcw_mode_e        hold_mode, act_mode;
   logic             run, term;

   tcw_cfg #(.CNT_W(CNT_W), .MIN_TC(MIN_TC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_tc(cfg_tc),
      .wr_mode(cfg_mode), .hold_tc(hold_tc), .hold_mode(hold_mode));

   tcw_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .start(start_cmd), .stop(stop_cmd),
      .hold_tc(hold_tc), .hold_mode(hold_mode), .run(run), .cnt(cnt),
      .act_tc(act_tc), .act_mode(act_mode), .term(term));

   tcw_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(term), .clr(flag_rd), .flag(tc_flag));

   tcw_wave #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_wave (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .act_tc(act_tc),
      .act_mode(act_mode), .wave(tmr_out));

   generate
      if (!REG_OUT) begin : g_chk
         // R8: the output is high in the cycle after a stop
         a_r8_stop_out_high: assert property (@(posedge clk) disable iff (!rst_n)
            stop_cmd |=> tmr_out);
         // R1: idle timer never raises a flag
         a_r1_idle_no_term: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !tc_flag && !flag_rd) |=> !tc_flag);
      end
   endgenerate
endmodule

// File: tb/sim_tc_wave_timer.sv
module sim_tc_wave_timer;
   localparam int CNT_W = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [CNT_W-1:0] cfg_tc = '0;
   logic [1:0]       cfg_mode = 2'b00;
   logic             start_cmd = 1'b0;
   logic             stop_cmd = 1'b0;
   logic             flag_rd = 1'b0;
   logic             tmr_out;
   logic             tc_flag;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   tc_wave_timer #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tc(cfg_tc),
      .cfg_mode(cfg_mode), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
      .flag_rd(flag_rd), .tmr_out(tmr_out), .tc_flag(tc_flag));

   task automatic chk(input logic act, input logic exp, input string req);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_write(input int tc, input int mode);
      cfg_wr = 1'b1; cfg_tc = CNT_W'(tc); cfg_mode = 2'(mode);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_start();
      start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
   endtask

   task automatic do_stop();
      stop_cmd = 1'b1; @(negedge clk); stop_cmd = 1'b0;
   endtask

   task automatic do_read();
      flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
   endtask

   function automatic logic exp_wave(input int m, input int t, input int k);
      int p;
      case (m)
         0: return (k > t) ? 1'b1 : (k <= (t + 1) / 2);
         1: begin p = (k - 1) % t + 1; return p <= (t + 1) / 2; end
         2: return k != t;
         default: return (k % t) != 0;
      endcase
   endfunction

   function automatic string mode_req(input int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(tmr_out, 1'b1, "R1 out");
      chk(tc_flag, 1'b0, "R1 flag");
      rst_n = 1'b1;
      @(negedge clk);
      chk(tmr_out, 1'b1, "R1 out after release");
      chk(tc_flag, 1'b0, "R1 flag after release");

      // sweep of all modes over TC 0..20 (R2..R6, R9)
      for (int m = 0; m < 4; m++) begin
         for (int tcv = 0; tcv <= 20; tcv++) begin
            int  t;
            logic ef;
            t = (tcv < 2) ? 2 : tcv;
            do_stop();
            do_read();
            do_write(tcv, m);
            do_start();
            ef = 1'b0;
            for (int k = 1; k <= 3 * t + 3; k++) begin
               chk(tmr_out, exp_wave(m, t, k),
                   (tcv < 2) ? "R6 clamped wave" : mode_req(m));
               chk(tc_flag, ef, "R9 flag sweep");
               if ((m < 2 || m == 2) && m != 1 && m != 3) begin
                  if (k == t) ef = 1'b1;
               end else if ((k % t) == 0) begin
                  ef = 1'b1;
               end
               @(negedge clk);
            end
         end
      end

      // R7: reprogramming during a repeating square wave
      do_stop(); do_read();
      do_write(6, 1);
      do_start();
      for (int k = 1; k <= 16; k++) begin
         logic e;
         e = (k <= 6) ? (k <= 3) : (((k - 6) % 4) != 0);
         chk(tmr_out, e, "R7 write takes effect at terminal count");
         if (k == 2) do_write(4, 3);
         else        @(negedge clk);
      end

      // R8: stop mid-run
      do_stop(); do_read();
      do_write(5, 3);
      do_start();
      for (int k = 1; k <= 3; k++) begin
         chk(tmr_out, 1'b1, "R8 before stop");
         if (k < 3) @(negedge clk);
      end
      do_stop();
      for (int k = 0; k < 12; k++) begin
         chk(tmr_out, 1'b1, "R8 out high after stop");
         chk(tc_flag, 1'b0, "R8 no flag after stop");
         @(negedge clk);
      end
      // R8: stop and start together
      start_cmd = 1'b1; stop_cmd = 1'b1;
      @(negedge clk);
      start_cmd = 1'b0; stop_cmd = 1'b0;
      for (int k = 0; k < 8; k++) begin
         chk(tmr_out, 1'b1, "R8 stop beats start");
         chk(tc_flag, 1'b0, "R8 stop beats start flag");
         @(negedge clk);
      end

      // R10: write without start
      do_write(3, 3);
      for (int k = 0; k < 8; k++) begin
         chk(tmr_out, 1'b1, "R10 no start out");
         chk(tc_flag, 1'b0, "R10 no start flag");
         @(negedge clk);
      end

      // R9: read strobe on a terminal edge, then a plain read
      do_stop(); do_read();
      do_write(3, 3);
      do_start();
      chk(tc_flag, 1'b0, "R9 cycle 1");
      @(negedge clk);
      chk(tc_flag, 1'b0, "R9 cycle 2");
      @(negedge clk);
      chk(tc_flag, 1'b0, "R9 cycle 3");
      do_read();
      chk(tc_flag, 1'b1, "R9 set wins over read");
      do_read();
      chk(tc_flag, 1'b0, "R9 read clears");
      @(negedge clk);
      chk(tc_flag, 1'b0, "R9 cycle 6");
      @(negedge clk);
      chk(tc_flag, 1'b1, "R9 set again");
      do_stop();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule